// File: doc/BRIEF.md
# Programmable LED Output Controller

This block produces the drive-low enables for two active-low status LEDs. Each pin has its own 2-bit mode field. In normal mode pin 0 lights on port activity and pin 1 lights on collisions. The other modes force the LED on, force it off, or make it blink from one blink generator that both pins share. A separate select bit makes pin 1 show the link-pass state instead of collisions. This happens only while pin 1 is in normal mode.

Activity and collision events are often a single clock long, so each one is stretched to a minimum visible on-time. A new event during the window restarts it. Each output is a registered enable. A 1 means the pad pulls low, which lights the LED. A 0 means the pad is released and the external pull-up turns the LED off. The pad circuit sits outside this block.

Top module: `led_ctrl`

## Requirements
- R1: While reset is asserted, both `drv_low_o` bits are 0 (released). The blink generator restarts in its released phase.
- R2: A mode field of 2'b01 (forced on) makes that pin's `drv_low_o` bit 1 in the cycle after the mode is applied.
- R3: A mode field of 2'b10 (forced off) makes that pin's `drv_low_o` bit 0 in the following cycle. This holds whatever the activity, collision and link inputs are doing.
- R4: With mode 2'b00 (normal), `drv_low_o[0]` follows stretched activity and `drv_low_o[1]` follows stretched collision, one cycle after the input.
- R5: A single-cycle activity or collision event keeps the pin driven for exactly STRETCH_CYC consecutive cycles.
- R6: An event that arrives while a stretch window is running restarts the window at full length.
- R7: With mode 2'b11 (blink), the pin alternates between driven and released every BLINK_HALF cycles. The first released stretch begins at reset release. Both pins in blink are in phase.
- R8: With `link_sel_i`=1 and mode1=2'b00, `drv_low_o[1]` follows `link_pass_i` one cycle later, and collisions do not affect pin 1.
- R9: `link_sel_i` has no effect when mode1 is not 2'b00, and it never affects pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode0_i | input | 2 | Pin 0 mode: 00 normal, 01 on, 10 off, 11 blink |
| mode1_i | input | 2 | Pin 1 mode, same encoding |
| link_sel_i | input | 1 | Pin 1 shows link-pass instead of collision in normal mode |
| coll_i | input | 1 | Collision event |
| act_i | input | 1 | Activity event |
| link_pass_i | input | 1 | Link is in pass state |
| drv_low_o | output | 2 | Per-pin drive-low enable, 1 = LED lit |

## Verification
The hardest case to reach is a retrigger: a second event must land inside a running stretch window, and the bench must show that the on-time then restarts in full rather than adding to the old window or being cut short. The stimulus uses a short stretch length. It sends a pulse and then a second pulse two cycles later, and a cycle-accurate model in the bench predicts the exact cycle in which the pin releases. Blink phase is checked every cycle against a count of edges since reset release. The same check runs while the other pin switches modes, which shows that the blink generator is shared and keeps running.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

    typedef enum logic [1:0] {
        LED_NORMAL = 2'b00,
        LED_ON     = 2'b01,
        LED_OFF    = 2'b10,
        LED_BLINK  = 2'b11
    } led_mode_e;

endpackage

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
    parameter int BLINK_HALF = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);
    localparam int CW = (BLINK_HALF > 2) ? $clog2(BLINK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } blink_st_t;

    blink_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.ph  = ~st_q.ph;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.ph;
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
    parameter int STRETCH_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    output logic active_o
);
    localparam int CW = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(STRETCH_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          running;

    assign running = (cnt_q != '0);

    always_comb begin
        if (ev_i)         cnt_d = RELOAD;
        else if (running) cnt_d = cnt_q - 1'b1;
        else              cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = ev_i | running;
endmodule

// File: rtl/led_pin_sel.sv
module led_pin_sel
    import led_ctrl_pkg::*;
(
    input  led_mode_e mode_i,
    input  logic      normal_i,
    input  logic      blink_i,
    output logic      drv_o
);
    always_comb begin
        unique case (mode_i)
            LED_NORMAL: drv_o = normal_i;
            LED_ON:     drv_o = 1'b1;
            LED_OFF:    drv_o = 1'b0;
            LED_BLINK:  drv_o = blink_i;
            default:    drv_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/led_ctrl.sv
module led_ctrl
    import led_ctrl_pkg::*;
#(
    parameter int BLINK_HALF  = 2_000_000,
    parameter int STRETCH_CYC = 1_000_000,
    parameter int NPIN        = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode0_i,
    input  logic [1:0] mode1_i,
    input  logic       link_sel_i,
    input  logic       coll_i,
    input  logic       act_i,
    input  logic       link_pass_i,
    output logic [1:0] drv_low_o
);
    typedef struct packed {
        logic [NPIN-1:0] drv;
    } out_st_t;

    out_st_t out_d, out_q;

    logic            blink_ph;
    logic [NPIN-1:0] ev_raw, ev_str, normal_src, pin_drv;
    led_mode_e       pin_mode [NPIN];

    assign ev_raw      = {coll_i, act_i};
    assign pin_mode[0] = led_mode_e'(mode0_i);
    assign pin_mode[1] = led_mode_e'(mode1_i);

    assign normal_src[0] = ev_str[0];
    assign normal_src[1] = link_sel_i ? link_pass_i : ev_str[1];

    led_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (blink_ph)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        led_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_str (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (ev_raw[p]),
            .active_o (ev_str[p])
        );
        led_pin_sel u_sel (
            .mode_i   (pin_mode[p]),
            .normal_i (normal_src[p]),
            .blink_i  (blink_ph),
            .drv_o    (pin_drv[p])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.drv = pin_drv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign drv_low_o = out_q.drv;
endmodule

// File: rtl/led_ctrl_chk.sv
module led_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode0_i,
    input logic [1:0] mode1_i,
    input logic       link_sel_i,
    input logic       act_i,
    input logic       link_pass_i,
    input logic [1:0] drv_low_o
);
    assert_on_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0_i == 2'b01) |=> drv_low_o[0]);

    assert_off_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1_i == 2'b10) |=> !drv_low_o[1]);

    assert_act_lights_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0_i == 2'b00 && act_i) |=> drv_low_o[0]);

    assert_blink_in_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0_i == 2'b11 && mode1_i == 2'b11) |=> (drv_low_o[0] == drv_low_o[1]));

    assert_link_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sel_i && mode1_i == 2'b00) |=> (drv_low_o[1] == $past(link_pass_i)));
endmodule

bind led_ctrl led_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode0_i     (mode0_i),
    .mode1_i     (mode1_i),
    .link_sel_i  (link_sel_i),
    .act_i       (act_i),
    .link_pass_i (link_pass_i),
    .drv_low_o   (drv_low_o)
);

// File: tb/led_ctrl_tb.sv
module led_ctrl_tb;
    localparam int HALF = 6;
    localparam int LEN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode0 = 2'b00, mode1 = 2'b00;
    logic       lsel = 1'b0, coll = 1'b0, act = 1'b0, lp = 1'b0;
    logic [1:0] drv;

    int n_vec = 0;
    int n_bad = 0;

    logic [1:0] exp_q [$];
    string      tag_q [$];

    int   m_bcnt = 0;
    logic m_bph  = 1'b0;
    int   m_s0   = 0;
    int   m_s1   = 0;

    always #5 clk = ~clk;

    led_ctrl #(.BLINK_HALF(HALF), .STRETCH_CYC(LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode0_i(mode0), .mode1_i(mode1),
        .link_sel_i(lsel), .coll_i(coll), .act_i(act), .link_pass_i(lp),
        .drv_low_o(drv)
    );

    function automatic logic pick(logic [1:0] m, logic nsrc, logic ph);
        case (m)
            2'b00:   return nsrc;
            2'b01:   return 1'b1;
            2'b10:   return 1'b0;
            default: return ph;
        endcase
    endfunction

    // driver: called at a negedge, sets inputs, predicts the next registered output
    task automatic cyc(input logic [1:0] m0, input logic [1:0] m1, input logic ls,
                       input logic co, input logic ac, input logic lk, input string tag);
        logic a_str, c_str;
        logic [1:0] e;
        mode0 = m0; mode1 = m1; lsel = ls; coll = co; act = ac; lp = lk;
        a_str = ac | (m_s0 != 0);
        c_str = co | (m_s1 != 0);
        e[0] = pick(m0, a_str, m_bph);
        e[1] = pick(m1, ls ? lk : c_str, m_bph);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        m_s0 = ac ? LEN - 1 : (m_s0 != 0 ? m_s0 - 1 : 0);
        m_s1 = co ? LEN - 1 : (m_s1 != 0 ? m_s1 - 1 : 0);
        if (m_bcnt == HALF - 1) begin m_bcnt = 0; m_bph = ~m_bph; end
        else m_bcnt = m_bcnt + 1;
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (drv !== e) begin
                    n_bad++;
                    $display("FAIL %s: drv_low_o actual=%b expected=%b at %0t", t, drv, e, $time);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (drv !== 2'b00) begin
            n_bad++;
            $display("FAIL R1: reset drv_low_o actual=%b expected=00", drv);
        end
        rst_n = 1'b1;
        // R1: blink starts released after reset (model phase 0)
        for (int i = 0; i < 2; i++) cyc(2'b11, 2'b11, 0, 0, 0, 0, "R1");
        // R2: forced on
        for (int i = 0; i < 3; i++) cyc(2'b01, 2'b01, 0, 0, 0, 0, "R2");
        // R3: forced off with every status input high
        for (int i = 0; i < 3; i++) cyc(2'b10, 2'b10, 0, 1, 1, 1, "R3");
        for (int i = 0; i < 4; i++) cyc(2'b00, 2'b00, 0, 0, 0, 0, "R4");
        // R4: normal with long activity and collision patterns
        for (int i = 0; i < 5; i++) cyc(2'b00, 2'b00, 0, i[0], 1, 0, "R4");
        for (int i = 0; i < 6; i++) cyc(2'b00, 2'b00, 0, 0, 0, 0, "R4");
        // R5: single pulse on each event
        cyc(2'b00, 2'b00, 0, 1, 1, 0, "R5");
        for (int i = 0; i < 7; i++) cyc(2'b00, 2'b00, 0, 0, 0, 0, "R5");
        // R6: retrigger inside window
        cyc(2'b00, 2'b00, 0, 0, 1, 0, "R6");
        cyc(2'b00, 2'b00, 0, 0, 0, 0, "R6");
        cyc(2'b00, 2'b00, 0, 1, 1, 0, "R6");
        cyc(2'b00, 2'b00, 0, 0, 0, 0, "R6");
        cyc(2'b00, 2'b00, 0, 1, 0, 0, "R6");
        for (int i = 0; i < 7; i++) cyc(2'b00, 2'b00, 0, 0, 0, 0, "R6");
        // R8: link select in normal mode, collisions hidden
        for (int i = 0; i < 8; i++) cyc(2'b00, 2'b00, 1, 1, 0, i[1], "R8");
        for (int i = 0; i < 4; i++) cyc(2'b00, 2'b00, 0, 0, 0, 0, "R8");
        // R9: link select ignored in other modes and on pin 0
        for (int i = 0; i < 4; i++) cyc(2'b00, 2'b01, 1, 0, 0, i[0], "R9");
        for (int i = 0; i < 4; i++) cyc(2'b01, 2'b10, 1, 0, 0, 1, "R9");
        for (int i = 0; i < 8; i++) cyc(2'b10, 2'b11, 1, 1, 0, i[0], "R9");
        // R7: blink, both pins, then pin 1 changing modes while pin 0 blinks
        for (int i = 0; i < 30; i++) cyc(2'b11, 2'b11, 0, 0, 0, 0, "R7");
        for (int i = 0; i < 12; i++) cyc(2'b11, i[3] ? 2'b01 : 2'b11, 0, 0, 1, 0, "R7");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule